// File: doc/BRIEF.md
# MSI-X Vector Table and Pending Array

This block keeps the MSI-X vector table and the pending-bit array of one device function. Both sit behind a small memory-mapped window that takes aligned 32-bit reads and writes. The device core raises one-cycle event pulses, one per vector. For each pulse the block either issues a memory-write message request at once or records the event in the pending array.

A vector counts as masked when its own mask bit is set or the function-wide mask is set. A masked event leaves a pending bit behind. When the event is no longer masked, the pending message is released. Messages leave one at a time through a valid/ready handshake, lowest vector number first. Each request carries the 64-bit address and 32-bit data held in that vector's table entry.

The MSI-X enable bit and the function mask bit are not programmed through the window. The block captures them by watching configuration writes. While MSI-X is enabled, the legacy line interrupt and the plain MSI request are held off. The table holds either 5 or 17 entries. The size is taken from a strap input once after reset.

Top module: `msix_vec_table`

## Requirements
- R1: Entry i occupies byte offsets 16*i to 16*i+15 of the window. The dword at +0 holds the low address, +4 the high address and +8 the message data, and all three are readable and writable. Address bits 1:0 are ignored.
- R2: The dword at +12 of an entry is vector control. Only bit 0 (the vector mask) is stored. All other bits read as 0.
- R3: After reset, every address and data word reads 0, every vector mask reads 1, the pending array reads 0 and msg_valid is 0.
- R4: size_sel is sampled on the first clock after reset is released: 1 selects 17 entries and 0 selects 5. Later changes have no effect. Entries at or beyond the selected size read 0, writes to them are ignored, and events on those vectors are ignored.
- R5: The pending array occupies offsets 0x120 to 0x12F. Bit i of the dword at 0x120 is the pending bit of vector i. All other bits of the four dwords read 0, and writes to the array are ignored.
- R6: With MSI-X enabled, an event on an unmasked vector raises msg_valid with msg_addr = {high, low} and msg_data = the entry's data. These values stay stable until msg_ready is seen.
- R7: An event on a vector whose mask is 1, or arriving while the function mask is 1, sets that vector's pending bit and produces no request.
- R8: Clearing a vector's mask while the function mask is 0 and its pending bit is set produces its message. The pending bit clears in the cycle the request is accepted.
- R9: When the function mask goes from 1 to 0, every pending vector that is not individually masked is sent, in ascending vector order.
- R10: MSI-X enable and the function mask are loaded from cfg_msix_en and cfg_func_mask when cfg_wr is high. While enable is 1, irq_line_out and msi_out are 0. While enable is 0, they follow their inputs and events are ignored.
- R11: Entries holding the same address each send their own message when their events occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_sel | input | 1 | Table size strap: 1 = 17 entries, 0 = 5 entries |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when 1, read when 0 |
| reg_addr | input | 12 | Byte address within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cfg_wr | input | 1 | Configuration write to the message control register |
| cfg_msix_en | input | 1 | MSI-X enable value carried by the configuration write |
| cfg_func_mask | input | 1 | Function mask value carried by the configuration write |
| vec_evt | input | 17 | One-cycle event pulse per vector |
| irq_line_in | input | 1 | Legacy line interrupt from the core |
| msi_in | input | 1 | MSI request from the core |
| irq_line_out | output | 1 | Gated legacy line interrupt |
| msi_out | output | 1 | Gated MSI request |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The embedded assertions check on every cycle that:
- a presented request keeps its address and data until it is accepted;
- no request is launched while the function mask is set or MSI-X is disabled;
- the size choice never moves once locked;
- pending bits never appear above a 5-entry table.

Only the bench scenarios can show the rest:
- that the table and pending array map onto the right offsets;
- that a masked event is replayed after a per-vector or function-wide unmask;
- that vectors leave in ascending order;
- that aliased addresses still yield separate messages;
- that the legacy outputs are gated.

// File: rtl/msix_vec_table.sv
module msix_vec_table #(
  parameter int MAX_VEC   = 17,
  parameter int SMALL_VEC = 5,
  parameter int AW        = 12,
  parameter int PBA_OFF   = 'h120
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           size_sel,
  input  logic           reg_en,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           cfg_wr,
  input  logic           cfg_msix_en,
  input  logic           cfg_func_mask,
  input  logic [MAX_VEC-1:0] vec_evt,
  input  logic           irq_line_in,
  input  logic           msi_in,
  output logic           irq_line_out,
  output logic           msi_out,
  output logic           msg_valid,
  input  logic           msg_ready,
  output logic [63:0]    msg_addr,
  output logic [31:0]    msg_data
);
  localparam int IW = $clog2(MAX_VEC);
  localparam logic [AW-1:0] PBA_A = AW'(PBA_OFF);

  logic [31:0] lo_q [MAX_VEC];
  logic [31:0] hi_q [MAX_VEC];
  logic [31:0] dat_q [MAX_VEC];
  logic [MAX_VEC-1:0] vmask_q, pend_q, fire_q;
  logic big_q, lock_q, en_q, fmask_q;
  logic out_vld;
  logic [IW-1:0] out_idx;
  logic [63:0] out_addr;
  logic [31:0] out_data;

  int nvec;
  always_comb nvec = big_q ? MAX_VEC : SMALL_VEC;

  logic [MAX_VEC-1:0] live;
  for (genvar i = 0; i < MAX_VEC; i++) begin : g_live
    assign live[i] = (i < nvec);
  end

  logic [AW-5:0] ent;
  logic [1:0]    fld;
  logic [IW-1:0] ridx;
  logic          in_tab, in_pba;
  logic          unused_lsb;
  assign ent    = reg_addr[AW-1:4];
  assign fld    = reg_addr[3:2];
  assign ridx   = ent[IW-1:0];
  assign in_tab = int'(ent) < nvec;
  assign in_pba = ent == PBA_A[AW-1:4];
  assign unused_lsb = ^reg_addr[1:0];

  always_comb begin
    reg_rdata = '0;
    if (in_tab) begin
      case (fld)
        2'd0: reg_rdata = lo_q[ridx];
        2'd1: reg_rdata = hi_q[ridx];
        2'd2: reg_rdata = dat_q[ridx];
        default: reg_rdata = {31'b0, vmask_q[ridx]};
      endcase
    end else if (in_pba && fld == 2'd0) begin
      reg_rdata = 32'(pend_q);
    end
  end

  assign irq_line_out = irq_line_in & ~en_q;
  assign msi_out      = msi_in & ~en_q;

  logic [MAX_VEC-1:0] masked, evt_ok, held, cand, clr;
  logic [IW-1:0] pick;
  logic found, take, acc;

  assign masked = vmask_q | {MAX_VEC{fmask_q}};
  assign evt_ok = vec_evt & live & {MAX_VEC{en_q}};
  assign held   = {{(MAX_VEC-1){1'b0}}, out_vld} << out_idx;
  assign cand   = (fire_q | pend_q) & ~masked & ~held;
  assign acc    = out_vld & msg_ready;
  assign clr    = acc ? held : '0;
  assign found  = |cand;
  assign take   = en_q & found & (~out_vld | msg_ready);

  always_comb begin
    pick = '0;
    for (int i = MAX_VEC - 1; i >= 0; i--)
      if (cand[i]) pick = i[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      big_q <= 1'b0; lock_q <= 1'b0;
      en_q <= 1'b0; fmask_q <= 1'b0;
    end else begin
      if (!lock_q) begin
        big_q  <= size_sel;
        lock_q <= 1'b1;
      end
      if (cfg_wr) begin
        en_q    <= cfg_msix_en;
        fmask_q <= cfg_func_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_VEC; i++) begin
        lo_q[i] <= '0; hi_q[i] <= '0; dat_q[i] <= '0;
      end
      vmask_q <= '1;
    end else if (reg_en && reg_we && in_tab) begin
      case (fld)
        2'd0: lo_q[ridx]  <= reg_wdata;
        2'd1: hi_q[ridx]  <= reg_wdata;
        2'd2: dat_q[ridx] <= reg_wdata;
        default: vmask_q[ridx] <= reg_wdata[0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= '0;
      pend_q <= '0;
    end else begin
      fire_q <= (fire_q & ~masked & ~clr) | (evt_ok & ~masked);
      pend_q <= (pend_q & ~clr) | (fire_q & masked & ~clr) | (evt_ok & masked);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0; out_idx <= '0;
      out_addr <= '0; out_data <= '0;
    end else begin
      if (acc) out_vld <= 1'b0;
      if (take) begin
        out_vld  <= 1'b1;
        out_idx  <= pick;
        out_addr <= {hi_q[pick], lo_q[pick]};
        out_data <= dat_q[pick];
      end
    end
  end

  assign msg_valid = out_vld;
  assign msg_addr  = out_addr;
  assign msg_data  = out_data;

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R7
  fmask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> !$past(fmask_q));

  // R10
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(en_q));

  // R4
  size_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && $past(lock_q) |-> $stable(big_q));

  // R4
  small_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && !big_q |-> pend_q[MAX_VEC-1:SMALL_VEC] == '0);

endmodule

// File: tb/sim_msix_vec_table.sv
module sim_msix_vec_table;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic size_sel = 1'b1;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cfg_wr = 1'b0, cfg_msix_en = 1'b0, cfg_func_mask = 1'b0;
  logic [16:0] vec_evt = '0;
  logic irq_line_in = 1'b0, msi_in = 1'b0;
  logic irq_line_out, msi_out;
  logic msg_valid, msg_ready = 1'b0;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msix_vec_table u0 (.*);

  localparam int NV = 16;
  localparam logic [76:0] TV [NV] = '{
    {1'b1, 12'h000, 32'h1111_0000, 32'h0},
    {1'b0, 12'h000, 32'h0,         32'h1111_0000},
    {1'b1, 12'h004, 32'h2222_0000, 32'h0},
    {1'b0, 12'h007, 32'h0,         32'h2222_0000},
    {1'b1, 12'h008, 32'h3333_0000, 32'h0},
    {1'b0, 12'h008, 32'h0,         32'h3333_0000},
    {1'b1, 12'h00C, 32'hFFFF_FFFE, 32'h0},
    {1'b0, 12'h00C, 32'h0,         32'h0},
    {1'b1, 12'h00C, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h00C, 32'h0,         32'h1},
    {1'b1, 12'h104, 32'hA5A5_A5A5, 32'h0},
    {1'b0, 12'h104, 32'h0,         32'hA5A5_A5A5},
    {1'b1, 12'h110, 32'h1234_5678, 32'h0},
    {1'b0, 12'h110, 32'h0,         32'h0},
    {1'b1, 12'h120, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h124, 32'h0,         32'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] e);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, {32'h0, reg_rdata}, {32'h0, e});
  endtask

  task automatic cfg(input logic en, input logic fm);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_msix_en = en; cfg_func_mask = fm;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [16:0] m);
    @(negedge clk);
    vec_evt = m;
    @(negedge clk);
    vec_evt = '0;
  endtask

  task automatic entry(input int v, input logic [31:0] hi, input logic [31:0] lo,
                       input logic [31:0] d, input logic msk);
    wr(12'(16 * v), lo);
    wr(12'(16 * v + 4), hi);
    wr(12'(16 * v + 8), d);
    wr(12'(16 * v + 12), {31'b0, msk});
  endtask

  task automatic collect(input string req, input logic [63:0] ea, input logic [31:0] ed);
    int n = 0;
    while (!msg_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(req, {63'b0, msg_valid}, 64'h1);
    chk(req, msg_addr, ea);
    chk(req, {32'h0, msg_data}, {32'h0, ed});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic quiet(input string req);
    int seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
    chk(req, 64'(seen), 64'h0);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; size_sel = s;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    // R3 reset state
    rd("R3", 12'h00C, 32'h1);
    rd("R3", 12'h108, 32'h0);
    rd("R3", 12'h120, 32'h0);
    chk("R3", {63'b0, msg_valid}, 64'h0);

    // R1 R2 R4 R5 register map vectors
    for (int i = 0; i < NV; i++) begin
      if (TV[i][76]) wr(TV[i][75:64], TV[i][63:32]);
      else rd("R1/R2/R4/R5 table", TV[i][75:64], TV[i][31:0]);
    end

    // R10 gating and disabled events
    irq_line_in = 1'b1; msi_in = 1'b1;
    #1 chk("R10 pass", {62'b0, irq_line_out, msi_out}, 64'h3);
    entry(1, 32'h1, 32'h0000_1000, 32'hD1, 1'b0);
    pulse(17'h2);
    quiet("R10 disabled");
    rd("R10 disabled pba", 12'h120, 32'h0);
    cfg(1'b1, 1'b0);
    #1 chk("R10 gate", {62'b0, irq_line_out, msi_out}, 64'h0);

    // R6 unmasked send with hold
    pulse(17'h2);
    repeat (4) @(negedge clk);
    chk("R6 hold", msg_addr, 64'h1_0000_1000);
    collect("R6", 64'h1_0000_1000, 32'hD1);

    // R7 R8 per-vector mask and replay
    entry(2, 32'h0, 32'h0000_2000, 32'hD2, 1'b1);
    pulse(17'h4);
    quiet("R7");
    rd("R7 pba", 12'h120, 32'h4);
    wr(12'h02C, 32'h0);
    collect("R8", 64'h2000, 32'hD2);
    rd("R8 pba clear", 12'h120, 32'h0);

    // R9 function mask replay in ascending order
    entry(3, 32'h0, 32'h3000, 32'hD3, 1'b0);
    entry(4, 32'h0, 32'h4000, 32'hD4, 1'b0);
    entry(16, 32'hA5A5_A5A5, 32'h16000, 32'hD16, 1'b0);
    cfg(1'b1, 1'b1);
    pulse(17'h10000);
    pulse(17'h8);
    pulse(17'h10);
    quiet("R7 fmask");
    rd("R5 bit16", 12'h120, 32'h0001_0018);
    cfg(1'b1, 1'b0);
    collect("R9 first", 64'h3000, 32'hD3);
    collect("R9 second", 64'h4000, 32'hD4);
    collect("R9 third", 64'hA5A5_A5A5_0001_6000, 32'hD16);
    rd("R9 pba clear", 12'h120, 32'h0);

    // R11 aliasing
    entry(5, 32'h0, 32'hCAFE_0000, 32'hE5, 1'b0);
    entry(6, 32'h0, 32'hCAFE_0000, 32'hE6, 1'b0);
    pulse(17'h60);
    collect("R11 a", 64'hCAFE_0000, 32'hE5);
    collect("R11 b", 64'hCAFE_0000, 32'hE6);

    // R4 small table
    do_reset(1'b0);
    wr(12'h050, 32'h77);
    rd("R4 beyond", 12'h050, 32'h0);
    wr(12'h040, 32'h44);
    rd("R4 inside", 12'h040, 32'h44);
    wr(12'h05C, 32'h0);
    cfg(1'b1, 1'b0);
    pulse(17'h20);
    quiet("R4 event");
    rd("R4 pba", 12'h120, 32'h0);
    size_sel = 1'b1;
    repeat (3) @(negedge clk);
    wr(12'h050, 32'h99);
    rd("R4 locked", 12'h050, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule